// File: doc/BRIEF.md
# Flash Program/Erase Status Register

This block holds the status word that a flash program/erase sequencer reports to software. Five bits carry engine state: a ready flag, an erase-suspended flag and three error flags for erase failure, program failure and low programming supply. The sequencer drives single-cycle event pulses into the block. The ready and suspended flags follow the engine. The error flags latch, and they stay set until software issues a clear-status strobe. A run of program or erase operations can therefore be checked once, at the end of the run.

Reads are framed by active-low chip-enable and output-enable, which are sampled on the clock. The value presented to the data bus is captured in the cycle where both enables first become active, which is whenever the later of the two falls. That value then holds for the rest of the read, even if the engine changes the status meanwhile. To see a fresh value, the reader must release an enable and assert it again. A byte/word select decides what the upper data byte does. In word mode the upper byte is driven as zero. In byte mode the upper byte is not driven.

Top module: `flash_sts_reg`

## Requirements
- R1: When rst_ni is asserted, the whole status word clears to 0 at once. The next read after that returns 00h on the low byte.
- R2: A read places the status on data bits 7..3 in this order: ready (7), erase suspended (6), erase error (5), program error (4), supply low (3). Bits 2..0 always read 0.
- R3: rdy_set_i sets the ready bit and rdy_clr_i clears it. If both arrive in the same cycle, the bit is set.
- R4: susp_i sets both the ready bit and the suspended bit. resume_i clears both. If both arrive in the same cycle, suspend wins.
- R5: ers_fail_i, pgm_fail_i and vpp_low_i each set their own error bit. rdy_clr_i, resume_i and rdy_set_i never clear an error bit.
- R6: clr_sts_i clears bits 5..3 and leaves bits 7 and 6 unchanged. If an error event arrives in the same cycle as clr_sts_i, that error bit ends up set.
- R7: The read value is taken in the first cycle in which ce_ni and oe_ni are both low, from the status held before that cycle's update. It holds unchanged for as long as both enables stay low.
- R8: A later status change becomes visible only after an enable goes high and then low again.
- R9: In word mode (byte_mode_i = 0) during a read, all 16 output-enable bits are 1 and data bits 15..8 are 0.
- R10: In byte mode (byte_mode_i = 1) during a read, output-enable bits 15..8 are 0 and bits 7..0 are 1.
- R11: When no read is active, data_o and data_oe_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset / power-down clear |
| rdy_set_i | input | 1 | Engine became ready (pulse) |
| rdy_clr_i | input | 1 | Engine started an operation (pulse) |
| susp_i | input | 1 | Erase suspended (pulse) |
| resume_i | input | 1 | Erase resumed (pulse) |
| pgm_fail_i | input | 1 | Program failure event (pulse) |
| ers_fail_i | input | 1 | Erase failure event (pulse) |
| vpp_low_i | input | 1 | Programming supply low event (pulse) |
| clr_sts_i | input | 1 | Software clear of the error bits (pulse) |
| ce_ni | input | 1 | Chip enable, active low, sampled on the clock |
| oe_ni | input | 1 | Output enable, active low, sampled on the clock |
| byte_mode_i | input | 1 | 1 = byte mode, 0 = word mode |
| data_o | output | 16 | Read data |
| data_oe_o | output | 16 | Per-bit drive enable for data_o |

## Verification
The assertions take for granted that the enables and event pulses are synchronous to clk_i and stable around its rising edge. They also take for granted that byte_mode_i changes only between reads. The bench drives every input at the falling clock edge. It changes byte_mode_i only while both enables are high. It holds reads for several cycles, so that the engine events land inside an active read. It also issues set/clear and error/clear pairs in the same cycle, to check each priority rule.

// File: rtl/flash_sts_pkg.sv
package flash_sts_pkg;
  localparam int STS_W   = 8;
  localparam int FLAG_LO = 3;

  typedef struct packed {
    logic ready;
    logic susp;
    logic ers_err;
    logic pgm_err;
    logic vpp_low;
  } sts_t;

  function automatic logic [STS_W-1:0] sts_to_byte(input sts_t s);
    return {s, {FLAG_LO{1'b0}}};
  endfunction
endpackage

// File: rtl/sts_core.sv
module sts_core
  import flash_sts_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_set_i,
  input  logic rdy_clr_i,
  input  logic susp_i,
  input  logic resume_i,
  input  logic pgm_fail_i,
  input  logic ers_fail_i,
  input  logic vpp_low_i,
  input  logic clr_sts_i,
  output sts_t sts_o
);
  sts_t q, d;

  always_comb begin
    // set terms dominate clear terms on every bit
    d.ready   = (q.ready & ~(rdy_clr_i | resume_i)) | rdy_set_i | susp_i;
    d.susp    = (q.susp & ~resume_i) | susp_i;
    d.ers_err = (q.ers_err & ~clr_sts_i) | ers_fail_i;
    d.pgm_err = (q.pgm_err & ~clr_sts_i) | pgm_fail_i;
    d.vpp_low = (q.vpp_low & ~clr_sts_i) | vpp_low_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign sts_o = q;

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(q.ers_err) && !$past(clr_sts_i)) |-> q.ers_err);
  assert_err_beats_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sts_i && pgm_fail_i) |=> q.pgm_err);
  assert_clr_keeps_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sts_i && !rdy_clr_i && !resume_i) |=> (q.ready || !$past(q.ready)));
  assert_susp_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_i |=> (q.ready && q.susp));
  assert_resume_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && !susp_i && !rdy_set_i) |=> (!q.ready && !q.susp));
endmodule

// File: rtl/sts_capture.sv
module sts_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         oe_ni,
  input  logic [W-1:0] live_i,
  output logic         rd_act_o,
  output logic [W-1:0] snap_o
);
  logic         act_q;
  logic         rise;
  logic [W-1:0] snap_q;

  assign rd_act_o = ~ce_ni & ~oe_ni;
  assign rise     = rd_act_o & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      act_q <= rd_act_o;
      if (rise) snap_q <= live_i;
    end
  end

  // bypass so the first read cycle already shows the captured value
  assign snap_o = rise ? live_i : snap_q;

  assert_hold_in_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act_o && act_q) |-> (snap_o == snap_q));
  assert_snap_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act_o && $past(rd_act_o)) |-> $stable(snap_o));
endmodule

// File: rtl/sts_drive.sv
module sts_drive #(
  parameter int DATA_W = 16,
  parameter int LOW_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_act_i,
  input  logic              byte_mode_i,
  input  logic [LOW_W-1:0]  snap_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);
  localparam int UP_W = DATA_W - LOW_W;

  assign data_o[LOW_W-1:0]    = rd_act_i ? snap_i : '0;
  assign data_oe_o[LOW_W-1:0] = {LOW_W{rd_act_i}};

  generate
    if (UP_W > 0) begin : g_upper
      // word mode drives zeros; byte mode releases the upper lines
      assign data_o[DATA_W-1:LOW_W]    = '0;
      assign data_oe_o[DATA_W-1:LOW_W] = {UP_W{rd_act_i & ~byte_mode_i}};
    end
  endgenerate

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_act_i |-> (data_oe_o == '0 && data_o == '0));
  assert_low_bits_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o[2:0] == 3'b000);
endmodule

// File: rtl/flash_sts_reg.sv
module flash_sts_reg
  import flash_sts_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rdy_set_i,
  input  logic              rdy_clr_i,
  input  logic              susp_i,
  input  logic              resume_i,
  input  logic              pgm_fail_i,
  input  logic              ers_fail_i,
  input  logic              vpp_low_i,
  input  logic              clr_sts_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              byte_mode_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);
  sts_t             sts;
  logic             rd_act;
  logic [STS_W-1:0] snap;

  sts_core u_core (
    .clk_i, .rst_ni, .rdy_set_i, .rdy_clr_i, .susp_i, .resume_i,
    .pgm_fail_i, .ers_fail_i, .vpp_low_i, .clr_sts_i, .sts_o(sts)
  );

  sts_capture #(.W(STS_W)) u_cap (
    .clk_i, .rst_ni, .ce_ni, .oe_ni,
    .live_i(sts_to_byte(sts)), .rd_act_o(rd_act), .snap_o(snap)
  );

  sts_drive #(.DATA_W(DATA_W), .LOW_W(STS_W)) u_drv (
    .clk_i, .rst_ni, .rd_act_i(rd_act), .byte_mode_i,
    .snap_i(snap), .data_o, .data_oe_o
  );

  assert_byte_mode_float_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && byte_mode_i) |-> (data_oe_o[DATA_W-1:STS_W] == '0));
  assert_word_mode_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && !byte_mode_i) |-> (data_oe_o == '1 && data_o[DATA_W-1:STS_W] == '0));
endmodule

// File: tb/sim_flash_sts_reg.sv
module sim_flash_sts_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0;
  logic rdy_set = 0, rdy_clr = 0, susp = 0, resume = 0;
  logic pgm_fail = 0, ers_fail = 0, vpp_low = 0, clr_sts = 0;
  logic ce_n = 1, oe_n = 1, byte_mode = 0;
  logic [15:0] data, data_oe;

  int checks = 0, failures = 0;
  string tag = "R1";

  logic [4:0] m_sts = 0;
  logic       m_prev = 0;
  logic [7:0] m_snap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_sts_reg u0 (
    .clk_i(clk), .rst_ni, .rdy_set_i(rdy_set), .rdy_clr_i(rdy_clr),
    .susp_i(susp), .resume_i(resume), .pgm_fail_i(pgm_fail),
    .ers_fail_i(ers_fail), .vpp_low_i(vpp_low), .clr_sts_i(clr_sts),
    .ce_ni(ce_n), .oe_ni(oe_n), .byte_mode_i(byte_mode),
    .data_o(data), .data_oe_o(data_oe)
  );

  task automatic chk(input string t, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got %h expected %h", t, got, exp);
    end
  endtask

  task automatic compare();
    logic act, rise;
    logic [7:0] live, low;
    act  = !ce_n && !oe_n;
    rise = act && !m_prev;
    live = {m_sts, 3'b000};
    low  = act ? (rise ? live : m_snap) : 8'h00;
    chk({tag, " data"}, data, {8'h00, low});
    chk("R2 low bits", {13'b0, data[2:0]}, 16'h0);
    if (!act) chk("R11 oe idle", data_oe, 16'h0);
    else if (byte_mode) chk("R10 oe byte", data_oe, 16'h00ff);
    else chk("R9 oe word", data_oe, 16'hffff);
  endtask

  task automatic model_step();
    logic act;
    logic r, s, e, p, v;
    act = !ce_n && !oe_n;
    if (act && !m_prev) m_snap = {m_sts, 3'b000};
    m_prev = act;
    {r, s, e, p, v} = m_sts;
    r = rdy_set || susp || (r && !rdy_clr && !resume);
    s = susp || (s && !resume);
    e = ers_fail || (e && !clr_sts);
    p = pgm_fail || (p && !clr_sts);
    v = vpp_low || (v && !clr_sts);
    m_sts = {r, s, e, p, v};
  endtask

  // inputs set at falling edge by caller; check, then advance model at rising edge
  task automatic cyc();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    {rdy_set, rdy_clr, susp, resume, pgm_fail, ers_fail, vpp_low, clr_sts} = '0;
  endtask

  task automatic rd(input int n);
    ce_n = 0; oe_n = 0;
    for (int i = 0; i < n; i++) cyc();
    ce_n = 1; oe_n = 1;
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog expired got hang expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    tag = "R1"; rd(2);
    chk("R1 reset word", data, 16'h0);

    tag = "R3"; rdy_set = 1; cyc(); rd(1);
    rdy_clr = 1; cyc(); rd(1);
    rdy_set = 1; rdy_clr = 1; cyc(); rd(1);

    tag = "R4"; susp = 1; cyc(); rd(1);
    resume = 1; cyc(); rd(1);
    susp = 1; resume = 1; cyc(); rd(1);

    tag = "R5"; pgm_fail = 1; cyc(); ers_fail = 1; cyc(); vpp_low = 1; cyc();
    rdy_clr = 1; resume = 1; cyc(); rdy_set = 1; cyc(); rd(1);

    tag = "R6"; clr_sts = 1; cyc(); rd(1);
    ers_fail = 1; clr_sts = 1; cyc(); rd(1);

    tag = "R7"; ce_n = 0; cyc(); oe_n = 0; cyc(); pgm_fail = 1; cyc(); rdy_clr = 1; cyc(); cyc();
    oe_n = 1; cyc(); ce_n = 1; cyc();
    oe_n = 0; cyc(); ce_n = 0; cyc(); vpp_low = 1; cyc(); cyc();

    tag = "R8"; oe_n = 1; cyc(); oe_n = 0; cyc(); cyc();
    ce_n = 1; oe_n = 1; cyc();

    tag = "R10"; byte_mode = 1; cyc(); rd(3);
    tag = "R9";  byte_mode = 0; cyc(); rd(3);

    tag = "R1"; susp = 1; cyc();
    ce_n = 0; oe_n = 0; cyc();
    rst_ni = 0; m_sts = 0; m_prev = 0; m_snap = 0;
    #1 compare();
    @(negedge clk); rst_ni = 1; ce_n = 1; oe_n = 1; cyc(); rd(1);

    tag = "RND";
    for (int i = 0; i < 4000; i++) begin
      rdy_set  = ($urandom % 8) == 0;
      rdy_clr  = ($urandom % 8) == 0;
      susp     = ($urandom % 16) == 0;
      resume   = ($urandom % 16) == 0;
      pgm_fail = ($urandom % 20) == 0;
      ers_fail = ($urandom % 20) == 0;
      vpp_low  = ($urandom % 24) == 0;
      clr_sts  = ($urandom % 12) == 0;
      if (($urandom % 5) == 0) ce_n = ~ce_n;
      if (($urandom % 5) == 0) oe_n = ~oe_n;
      if (ce_n && oe_n && ($urandom % 6) == 0) byte_mode = ~byte_mode;
      cyc();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule